// File: doc/BRIEF.md
# Serial Frame Master with Selectable Clock Polarity and Phase

This block is the master side of a synchronous serial link. Software-side logic pushes data words of 4 to 16 bits into an 8-entry transmit queue. The engine shifts each word out most significant bit first on a transmit line. At the same time it samples a receive line and pushes each received word into an 8-entry receive queue. It generates the serial clock and an active-low frame select. Clock polarity and clock phase can be chosen at run time. The half period of the serial clock is a fixed number of system clocks, set by a parameter.

With the second-edge phase (phase = 1), the frame select leads the first clock edge by half a serial period. It trails the last sampling edge by one full period, and it stays low across words that follow one another with no break. With the first-edge phase (phase = 0), the first bit is already on the line when frame select falls. Between queued words, frame select goes high for one full serial period. When no frame is running, the lines rest at defined levels. A role input drives the output enable of the clock pad.

Top module: `spi_frame_master`

## Requirements
- R1: The effective word length L is the `wordLen` input clamped to the range 4..16: values below 4 act as 4 and values above 16 act as 16. Each word goes out on `mosi` most significant bit first, taking the low L bits of the queued value.
- R2: A frame starts only when `enable` is 1, `masterRole` is 1 and the transmit queue is not empty. When it starts, `fsN` falls and `txOe` rises in the same cycle, and `txOe` stays 1 whenever `fsN` is low.
- R3: With `cpha`=1 and a single word, `mosi` changes on each leading clock edge and is sampled on each trailing edge. The first leading edge comes N system clocks after `fsN` falls. `fsN` stays low for (2L+2)·N system clocks.
- R4: With `cpha`=1 and more words queued, `fsN` stays low from word to word. For W words the frame lasts (2·L·W+2)·N system clocks.
- R5: With `cpha`=0, the first bit is on `mosi` when `fsN` falls and is sampled on each leading edge. Each word's frame lasts (2L+1)·N system clocks. Between queued words, `fsN` is high for exactly 2N system clocks.
- R6: `sclk` rests at the `cpol` level, so it idles high when `cpol`=1 and low when `cpol`=0. Each half period lasts N system clocks. Each word produces exactly 2L `sclk` edges, and all of them fall while `fsN` is low.
- R7: When no frame is active, `fsN`=1, `mosi`=0 and `txOe`=0. This also holds straight after reset.
- R8: `sclkOe` is 1 in master role (`masterRole`=1) and 0 in slave role. In slave role no frame starts.
- R9: `cpol` and `cpha` are captured at frame start. Changing them during a frame does not alter that frame's timing or data.
- R10: Each received word is pushed right-justified, with the bits above L set to zero. `rxData` shows the oldest unread word, and `rxPop` advances the queue.
- R11: If a word completes while the receive queue is full, the word is dropped and `rxOverrun` is set. `rxOverrun` stays set until reset.
- R12: Each queue holds 8 words and reports full and empty. A push into a full transmit queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new frames to start |
| masterRole | input | 1 | 1 = master role, 0 = slave role |
| cpol | input | 1 | Clock rest level |
| cpha | input | 1 | 1 = sample on the trailing edge, 0 = sample on the leading edge |
| wordLen | input | 5 | Requested word length in bits (clamped to 4..16) |
| txData | input | 16 | Word to queue for sending |
| txPush | input | 1 | Push `txData` into the transmit queue |
| txFull | output | 1 | Transmit queue full |
| txEmpty | output | 1 | Transmit queue empty |
| rxData | output | 16 | Oldest received word |
| rxPop | input | 1 | Remove the oldest received word |
| rxFull | output | 1 | Receive queue full |
| rxEmpty | output | 1 | Receive queue empty |
| rxOverrun | output | 1 | Sticky flag: a received word was dropped |
| miso | input | 1 | Serial receive line |
| sclk | output | 1 | Serial clock |
| sclkOe | output | 1 | Output enable for the clock pad |
| fsN | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial transmit line |
| txOe | output | 1 | Output enable for the transmit line |

## Verification
The bench runs single-word frames for every polarity and phase at every requested length from 2 to 18. This separates the clamped lengths from the honoured ones, and separates leading-edge sampling from trailing-edge sampling. Each transmit word is paired with a different receive word, so a swapped line or a misplaced bit shows up. Runs of three and four queued words tell the unbroken phase-1 frame apart from the phase-0 frames, which are split by a gap, and the measured low and high times are compared with the N-based formulas. Further runs change polarity and phase during a frame, hold off the start in slave role, and overfill both queues to show that words are dropped and the overrun flag is sticky.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_BITA,
    ST_BITB,
    ST_TAIL,
    ST_GAP1,
    ST_GAP2
  } fmState_e;

  typedef struct packed {
    logic loadWord;
    logic sampleRx;
    logic advanceBit;
    logic pushRx;
  } fmStrobe_t;

endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = mem[rdPtr];

  function automatic logic [AW-1:0] bumpPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bumpPtr(wrPtr);
      if (doPop)  rdPtr <= bumpPtr(rdPtr);
      if (doPush && !doPop)      count <= count + CW'(1);
      else if (doPop && !doPush) count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end
endmodule

// File: rtl/spi_fm_datapath.sv
module spi_fm_datapath
  import spi_fm_pkg::*;
#(
  parameter int WORD_MAX   = 16,
  parameter int FIFO_DEPTH = 8,
  localparam int LW        = $clog2(WORD_MAX + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  fmStrobe_t           strobe,
  input  logic [LW-1:0]       lenEff,
  input  logic                driveData,
  input  logic                txPush,
  input  logic [WORD_MAX-1:0] txData,
  input  logic                rxPop,
  input  logic                miso,
  output logic                mosi,
  output logic                txFull,
  output logic                txEmpty,
  output logic [WORD_MAX-1:0] rxData,
  output logic                rxFull,
  output logic                rxEmpty,
  output logic                rxOverrun
);
  logic [WORD_MAX-1:0] txHead;
  logic [WORD_MAX-1:0] txShift;
  logic [WORD_MAX-1:0] rxShift;

  spi_fm_fifo #(.WIDTH(WORD_MAX), .DEPTH(FIFO_DEPTH)) txQ_i (
    .clk(clk), .rstN(rstN),
    .push(txPush), .wrData(txData),
    .pop(strobe.loadWord), .rdData(txHead),
    .full(txFull), .empty(txEmpty)
  );

  spi_fm_fifo #(.WIDTH(WORD_MAX), .DEPTH(FIFO_DEPTH)) rxQ_i (
    .clk(clk), .rstN(rstN),
    .push(strobe.pushRx), .wrData(rxShift),
    .pop(rxPop), .rdData(rxData),
    .full(rxFull), .empty(rxEmpty)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift   <= '0;
      rxShift   <= '0;
      rxOverrun <= 1'b0;
    end else begin
      if (strobe.loadWord)        txShift <= txHead << (LW'(WORD_MAX) - lenEff);
      else if (strobe.advanceBit) txShift <= txShift << 1;
      if (strobe.loadWord)        rxShift <= '0;
      else if (strobe.sampleRx)   rxShift <= {rxShift[WORD_MAX-2:0], miso};
      if (strobe.pushRx && rxFull) rxOverrun <= 1'b1;
    end
  end

  assign mosi = driveData & txShift[WORD_MAX-1];
endmodule

// File: rtl/spi_fm_ctrl.sv
module spi_fm_ctrl
  import spi_fm_pkg::*;
#(
  parameter int DIV_N    = 2,
  parameter int WORD_MAX = 16,
  localparam int LW      = $clog2(WORD_MAX + 1),
  localparam int DW      = $clog2(DIV_N + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          masterRole,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [LW-1:0] lenEff,
  input  logic          txEmpty,
  output fmStrobe_t     strobe,
  output logic          sclk,
  output logic          fsN,
  output logic          txOe,
  output logic          driveData
);
  fmState_e      st, nxt;
  logic [DW-1:0] divCnt;
  logic [LW-1:0] bitsLeft;
  logic          cpolL, cphaL;
  logic          tick, canGo, active;

  assign tick  = (divCnt == DW'(DIV_N - 1));
  assign canGo = enable && masterRole && !txEmpty;

  always_comb begin
    nxt    = st;
    strobe = '0;
    unique case (st)
      ST_IDLE: if (canGo) begin
        strobe.loadWord = 1'b1;
        nxt = cpha ? ST_LEAD : ST_BITA;
      end
      ST_LEAD: if (tick) nxt = ST_BITA;
      ST_BITA: if (tick) begin
        strobe.sampleRx = 1'b1;
        nxt = ST_BITB;
      end
      ST_BITB: if (tick) begin
        if (bitsLeft != '0) begin
          strobe.advanceBit = 1'b1;
          nxt = ST_BITA;
        end else begin
          strobe.pushRx = 1'b1;
          if (cphaL && canGo) begin
            strobe.loadWord = 1'b1;
            nxt = ST_BITA;
          end else begin
            nxt = ST_TAIL;
          end
        end
      end
      ST_TAIL: if (tick) nxt = (!cphaL && canGo) ? ST_GAP1 : ST_IDLE;
      ST_GAP1: if (tick) nxt = ST_GAP2;
      ST_GAP2: if (tick) begin
        if (canGo) begin
          strobe.loadWord = 1'b1;
          nxt = ST_BITA;
        end else begin
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      divCnt   <= '0;
      bitsLeft <= '0;
      cpolL    <= 1'b0;
      cphaL    <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_IDLE || tick) divCnt <= '0;
      else                       divCnt <= divCnt + DW'(1);
      if (strobe.loadWord)        bitsLeft <= lenEff - LW'(1);
      else if (strobe.advanceBit) bitsLeft <= bitsLeft - LW'(1);
      if (st == ST_IDLE && canGo) begin
        cpolL <= cpol;
        cphaL <= cpha;
      end
    end
  end

  assign active    = cphaL ? (st == ST_BITA) : (st == ST_BITB);
  assign sclk      = (st == ST_IDLE) ? cpol : (cpolL ^ active);
  assign fsN       = (st inside {ST_IDLE, ST_GAP1, ST_GAP2});
  assign txOe      = (st != ST_IDLE);
  assign driveData = (st inside {ST_BITA, ST_BITB, ST_TAIL});
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_fm_pkg::*;
#(
  parameter int DIV_N      = 2,
  parameter int WORD_MAX   = 16,
  parameter int FIFO_DEPTH = 8,
  localparam int LW        = $clog2(WORD_MAX + 1),
  localparam int WORD_MIN  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                masterRole,
  input  logic                cpol,
  input  logic                cpha,
  input  logic [LW-1:0]       wordLen,
  input  logic [WORD_MAX-1:0] txData,
  input  logic                txPush,
  output logic                txFull,
  output logic                txEmpty,
  output logic [WORD_MAX-1:0] rxData,
  input  logic                rxPop,
  output logic                rxFull,
  output logic                rxEmpty,
  output logic                rxOverrun,
  input  logic                miso,
  output logic                sclk,
  output logic                sclkOe,
  output logic                fsN,
  output logic                mosi,
  output logic                txOe
);
  fmStrobe_t     strobe;
  logic [LW-1:0] lenEff;
  logic          driveData;

  always_comb begin
    if (wordLen < LW'(WORD_MIN))      lenEff = LW'(WORD_MIN);
    else if (wordLen > LW'(WORD_MAX)) lenEff = LW'(WORD_MAX);
    else                              lenEff = wordLen;
  end

  assign sclkOe = masterRole;

  spi_fm_ctrl #(.DIV_N(DIV_N), .WORD_MAX(WORD_MAX)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .masterRole(masterRole),
    .cpol(cpol), .cpha(cpha), .lenEff(lenEff), .txEmpty(txEmpty),
    .strobe(strobe), .sclk(sclk), .fsN(fsN), .txOe(txOe),
    .driveData(driveData)
  );

  spi_fm_datapath #(.WORD_MAX(WORD_MAX), .FIFO_DEPTH(FIFO_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lenEff(lenEff),
    .driveData(driveData), .txPush(txPush), .txData(txData),
    .rxPop(rxPop), .miso(miso), .mosi(mosi), .txFull(txFull),
    .txEmpty(txEmpty), .rxData(rxData), .rxFull(rxFull),
    .rxEmpty(rxEmpty), .rxOverrun(rxOverrun)
  );
endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic masterRole,
  input logic cpol,
  input logic txEmpty,
  input logic txFull,
  input logic rxFull,
  input logic rxEmpty,
  input logic rxOverrun,
  input logic sclk,
  input logic fsN,
  input logic mosi,
  input logic txOe
);
  a_r7_idle_lines: assert property (@(posedge clk) disable iff (!rstN)
    !txOe |-> (fsN && !mosi));

  a_r6_idle_clock: assert property (@(posedge clk) disable iff (!rstN)
    !txOe |-> (sclk == cpol));

  a_r2_start_cond: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fsN) |-> $past(enable && masterRole && !txEmpty));

  a_r2_oe_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    !fsN |-> txOe);

  a_r6_edges_framed: assert property (@(posedge clk) disable iff (!rstN)
    (txOe && $past(txOe) && (sclk != $past(sclk))) |-> (!fsN && !$past(fsN)));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |=> rxOverrun);

  a_r11_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrun) |-> $past(rxFull));

  a_r12_flags: assert property (@(posedge clk) disable iff (!rstN)
    !(txFull && txEmpty) && !(rxFull && rxEmpty));
endmodule

bind spi_frame_master spi_frame_master_chk chk_i (.*);

// File: tb/spi_frame_master_tb_top.sv
module spi_frame_master_tb_top;
  localparam int N = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, enable, masterRole, cpol, cpha, txPush, rxPop;
  logic [4:0]  wordLen;
  logic [15:0] txData;
  logic        miso = 1'b0;
  logic        txFull, txEmpty, rxFull, rxEmpty, rxOverrun;
  logic        sclk, sclkOe, fsN, mosi, txOe;
  logic [15:0] rxData;

  spi_frame_master #(.DIV_N(N)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .masterRole(masterRole),
    .cpol(cpol), .cpha(cpha), .wordLen(wordLen), .txData(txData),
    .txPush(txPush), .txFull(txFull), .txEmpty(txEmpty), .rxData(rxData),
    .rxPop(rxPop), .rxFull(rxFull), .rxEmpty(rxEmpty), .rxOverrun(rxOverrun),
    .miso(miso), .sclk(sclk), .sclkOe(sclkOe), .fsN(fsN), .mosi(mosi),
    .txOe(txOe)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;

  task automatic chkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // serial-side model: captures mosi at sampling edges, drives miso
  int monCpol = 0, monCpha = 0, monLen = 8;
  logic [15:0] misoWords [128];
  logic [15:0] capWords  [128];
  int nCap = 0, bitCnt = 0, edgeCnt = 0, nRise = 0;
  int fallCyc = 0, riseCyc = 0, lastLow = 0, lastGap = 0;
  logic [15:0] capTx = '0;
  logic prevSclk = 1'b0, prevFs = 1'b1;

  initial for (int i = 0; i < 128; i++) misoWords[i] = '0;

  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (prevFs && !fsN) begin
        fallCyc = cyc;
        if (nRise > 0) lastGap = cyc - riseCyc;
        miso = misoWords[nCap & 127][monLen-1];
      end
      if (!prevFs && fsN) begin
        riseCyc = cyc;
        lastLow = cyc - fallCyc;
        nRise++;
      end
      if (sclk !== prevSclk && !fsN) begin
        edgeCnt++;
        if (((sclk != monCpol) ? 1 : 0) != monCpha) begin
          capTx = {capTx[14:0], mosi};
          bitCnt++;
          if (bitCnt == monLen) begin
            capWords[nCap & 127] = capTx;
            nCap++;
            bitCnt = 0;
            capTx = '0;
          end
          miso = misoWords[nCap & 127][monLen-1-bitCnt];
        end
      end
    end
    prevSclk = sclk;
    prevFs = fsN;
  end

  function automatic int clampLen(input int len);
    return (len < 4) ? 4 : ((len > 16) ? 16 : len);
  endfunction

  task automatic pushWord(input logic [15:0] v);
    @(negedge clk);
    txData = v;
    txPush = 1'b1;
    @(negedge clk);
    txPush = 1'b0;
  endtask

  task automatic waitRises(input int target);
    while (nRise < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic popCheck(input string tag, input logic [15:0] exp);
    chkEq({tag, " rx not empty"}, rxEmpty, 0);
    chkEq(tag, rxData, exp);
    rxPop = 1'b1;
    @(negedge clk);
    rxPop = 1'b0;
  endtask

  task automatic setMode(input int pol, input int pha, input int len);
    cpol = pol[0]; cpha = pha[0]; wordLen = len[4:0];
    monCpol = pol; monCpha = pha; monLen = clampLen(len);
  endtask

  task automatic runWords(input int pol, input int pha, input int len,
                          input int count, input int seed);
    int effLen, mask, base, edge0, rise0;
    logic [15:0] tx [8];
    effLen = clampLen(len);
    mask = (1 << effLen) - 1;
    base = nCap; edge0 = edgeCnt; rise0 = nRise;
    enable = 1'b0;
    setMode(pol, pha, len);
    for (int i = 0; i < count; i++) begin
      tx[i] = 16'((seed * 73 + i * 29 + 16'h5A5) & mask);
      misoWords[(base + i) & 127] = 16'((seed * 131 + i * 57 + 16'h3C3) & mask);
      // upper bits above L filled so clamping/justification is visible (R1)
      pushWord(tx[i] | 16'(~mask & 16'hA000));
    end
    repeat (4) @(negedge clk);
    chkEq("R2 no start while disabled", fsN, 1);
    enable = 1'b1;
    waitRises(rise0 + ((pha == 1) ? 1 : count));
    for (int i = 0; i < count; i++)
      chkEq("R1 word sent MSB first", capWords[(base + i) & 127], tx[i]);
    for (int i = 0; i < count; i++)
      popCheck("R10 rx right-justified", misoWords[(base + i) & 127]);
    if (pha == 1) begin
      if (count == 1) chkEq("R3 frame low time", lastLow, (2 * effLen + 2) * N);
      else chkEq("R4 continuous low time", lastLow, (2 * effLen * count + 2) * N);
    end else begin
      chkEq("R5 frame low time", lastLow, (2 * effLen + 1) * N);
      if (count > 1) chkEq("R5 gap high time", lastGap, 2 * N);
    end
    chkEq("R6 edge count", edgeCnt - edge0, 2 * effLen * count);
    chkEq("R6 clock rest level", sclk, pol);
    chkEq("R7 idle fsN", fsN, 1);
    chkEq("R7 idle mosi", mosi, 0);
    chkEq("R7 idle txOe", txOe, 0);
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finishRun();
  end

  initial begin
    int base, rise0;
    rstN = 1'b0; enable = 1'b0; masterRole = 1'b1; cpol = 1'b0; cpha = 1'b0;
    wordLen = 5'd8; txData = '0; txPush = 1'b0; rxPop = 1'b0;
    repeat (5) @(negedge clk);
    chkEq("R7 reset fsN", fsN, 1);
    chkEq("R7 reset mosi", mosi, 0);
    chkEq("R7 reset txOe", txOe, 0);
    chkEq("R6 reset sclk", sclk, 0);
    chkEq("R12 reset txEmpty", txEmpty, 1);
    chkEq("R12 reset rxEmpty", rxEmpty, 1);
    chkEq("R11 reset overrun", rxOverrun, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R8: slave role holds off the frame and releases the clock pad
    setMode(0, 0, 8);
    masterRole = 1'b0;
    enable = 1'b1;
    base = nCap; rise0 = nRise;
    misoWords[base & 127] = 16'h3C;
    pushWord(16'h00A5);
    repeat (20) @(negedge clk);
    chkEq("R8 slave sclkOe", sclkOe, 0);
    chkEq("R8 slave no frame", fsN, 1);
    chkEq("R8 slave keeps word", txEmpty, 0);
    masterRole = 1'b1;
    @(negedge clk);
    chkEq("R8 master sclkOe", sclkOe, 1);
    waitRises(rise0 + 1);
    chkEq("R8 word after role change", capWords[base & 127], 16'hA5);
    popCheck("R10 rx after role change", 16'h3C);

    // sweep of modes and lengths, including clamped lengths (R1)
    for (int pol = 0; pol < 2; pol++)
      for (int pha = 0; pha < 2; pha++)
        for (int len = 2; len <= 18; len++)
          runWords(pol, pha, len, 1, len * 7 + pol * 3 + pha);

    // back-to-back words (R4, R5)
    for (int pol = 0; pol < 2; pol++)
      for (int pha = 0; pha < 2; pha++) begin
        runWords(pol, pha, 5, 3, 40 + pol * 2 + pha);
        runWords(pol, pha, 16, 4, 90 + pol * 2 + pha);
      end

    // R9: mode inputs changed mid-frame have no effect on this frame
    enable = 1'b0;
    setMode(0, 0, 8);
    base = nCap; rise0 = nRise;
    misoWords[base & 127] = 16'h96;
    pushWord(16'h0069);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    cpol = 1'b1; cpha = 1'b1;
    waitRises(rise0 + 1);
    chkEq("R9 low time kept", lastLow, (2 * 8 + 1) * N);
    chkEq("R9 data kept", capWords[base & 127], 16'h69);
    chkEq("R9 idle follows new cpol", sclk, 1);
    popCheck("R9 rx kept", 16'h96);
    cpol = 1'b0; cpha = 1'b0;

    // R11/R12: queue depth, ignored push, overrun drop
    enable = 1'b0;
    setMode(0, 0, 6);
    base = nCap; rise0 = nRise;
    for (int i = 0; i < 9; i++) misoWords[(base + i) & 127] = 16'((i * 11 + 5) & 63);
    for (int i = 0; i < 9; i++) pushWord(16'((i * 5 + 1) & 63));
    chkEq("R12 tx full at 8", txFull, 1);
    enable = 1'b1;
    waitRises(rise0 + 8);
    chkEq("R12 ninth push ignored", txEmpty, 1);
    chkEq("R12 rx full at 8", rxFull, 1);
    chkEq("R11 no overrun yet", rxOverrun, 0);
    pushWord(16'h2B);
    waitRises(rise0 + 9);
    chkEq("R11 overrun set", rxOverrun, 1);
    chkEq("R1 ninth word sent", capWords[(base + 8) & 127], 16'h2B);
    for (int i = 0; i < 8; i++)
      popCheck("R11 kept words", misoWords[(base + i) & 127]);
    chkEq("R11 dropped word absent", rxEmpty, 1);
    chkEq("R11 overrun sticky", rxOverrun, 1);

    finishRun();
  end
endmodule